// File: doc/BRIEF.md
# Recirculating Serial Shift Memory

This block is a cycle-level digital model of a dynamic serial store built as two long rotating shift registers that run side by side. Each register, called a half, is cut into equal segments. Every segment boundary passes the data through an inverting regenerator. The far end of each half feeds its bit back to the start, so stored data keeps circulating for as long as shifting continues. On each shift the two halves each present one bit, which gives two bits per shift clock. The bit from the even half is first in stream order, and the bit from the odd half follows it.

Writing is serial. On a shift with the write enable high, the bit that would have come back into the start of each half is replaced by the matching write-data bit. This overwrites the slot currently at the input. A random read names a bit address. The block keeps count of the rotation, works out where that bit sits now, and picks the next tap along the half that the bit will reach. Read taps are placed at a regular spacing along each half. When the bit reaches that tap the block returns it with its polarity corrected. Only one read is in flight at a time.

Top module: `recirc_shift_mem`

## Requirements
- R1: Address bit 0 selects the half (0 = even half, 1 = odd half). Bits 12..1 give the slot, which must be 0..2079. A read request whose slot is 2080 or above is dropped and never produces rd_valid.
- R2: With wr_en low, every stored bit is kept across any number of shifts, including full loops of 2080 shifts.
- R3: A shift with wr_en high replaces, in each half h, the slot equal to the current rotation count with wr_data[h]. wr_en while shift_en is low changes nothing.
- R4: The rotation count starts at 0 after reset, advances by one per shift and wraps from 2079 to 0. With shift_en low nothing moves and ser_out stays stable.
- R5: Between edges, ser_out[0] is the true value of the even-half slot equal to the rotation count, and ser_out[1] is the same for the odd half.
- R6: rd_data equals the bit last written to the addressed slot, in true polarity, whatever the number of regenerators the bit has crossed.
- R7: Let p = (rot - 1 - slot) mod 2080 be the physical position of the slot, where rot is the rotation count. Taps sit where p mod 130 = 129. Once a request is accepted, rd_valid rises one edge after the first cycle in which the slot sits at a tap. The cycles counted here start with the one right after the request edge. With a shift on every cycle, this is at most 130 edges after the request edge.
- R8: rd_valid is high for exactly one cycle per accepted request, and low at all other times.
- R9: A read request that arrives while a read is pending is ignored, so it never produces its own rd_valid.
- R10: A synchronous reset sets the rotation count to 0, drops any pending read and forces rd_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advance both halves by one position on this edge |
| wr_en | input | 1 | Replace the recirculated bit at the input of both halves |
| wr_data | input | 2 | Write bits: [0] even half, [1] odd half |
| rd_req | input | 1 | Start a random read of rd_addr |
| rd_addr | input | 13 | Bit address: [0] half, [12:1] slot |
| ser_out | output | 2 | Stream pair for this shift: [0] even half first, then [1] odd half |
| rd_valid | output | 1 | One-cycle strobe marking rd_data as the requested bit |
| rd_data | output | 1 | Polarity-corrected read bit |

## Verification
The hardest cases to reach from the ports are reads whose bit lies exactly on a tap at the request edge, and reads whose bit has just passed a tap. In the first case the read returns at the first possible edge. In the second the bit must travel the full tap spacing, which gives the worst-case latency. The bench tracks the rotation count from its own shift history. From that count it picks directed slot addresses that land on each of these phases, and on the phase one before a tap. It also mixes in random reads with gaps in shifting and a duplicate request fired during a pending read.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

   typedef enum logic {
      HALF_EVEN = 1'b0,
      HALF_ODD  = 1'b1
   } half_e;

   // Parity of the number of regenerators a bit at position pos has crossed
   function automatic logic crossing_parity(input int pos, input int seg_len);
      return ((pos / seg_len) % 2) != 0;
   endfunction

endpackage

// File: rtl/rsm_segment.sv
module rsm_segment #(
   parameter int LEN = 65
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift,
   input  logic           din,
   output logic [LEN-1:0] q,
   output logic           regen
);

   // q[0] is the first position of the segment, q[LEN-1] the last
   always_ff @(posedge clk) begin
      if (shift) begin
         q <= {q[LEN-2:0], din};
      end
   end

   // Inverting regenerator at the segment boundary
   assign regen = ~q[LEN-1];

   AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(q)); // R2

endmodule

// File: rtl/rsm_half.sv
module rsm_half #(
   parameter int SEG_LEN     = 65,
   parameter int SEGS        = 32,
   parameter int TAP_SPACING = 130,
   parameter int TAP_PHASE   = 129,
   parameter int NTAPS       = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift,
   input  logic             wr_en,
   input  logic             wr_bit,
   output logic             stream_bit,
   output logic [NTAPS-1:0] taps
);

   localparam int HALF_BITS = SEG_LEN * SEGS;

   logic [SEG_LEN-1:0] seg_q [SEGS];
   logic [SEGS-1:0]    regen;
   logic [SEGS-1:0]    seg_in;
   logic               loop_bit;

   for (genvar k = 0; k < SEGS; k++) begin : g_seg
      rsm_segment #(.LEN(SEG_LEN)) u_seg (
         .clk   (clk),
         .rst   (rst),
         .shift (shift),
         .din   (seg_in[k]),
         .q     (seg_q[k]),
         .regen (regen[k])
      );
      if (k == 0) begin : g_head
         assign seg_in[k] = wr_en ? wr_bit : loop_bit;
      end else begin : g_link
         assign seg_in[k] = regen[k-1];
         AST_REGEN_INV: assert property (@(posedge clk) disable iff (rst)
            shift |=> seg_q[k][0] == !$past(seg_q[k-1][SEG_LEN-1])); // R6
      end
   end

   // A full loop must come back in true polarity
   if ((SEGS % 2) == 0) begin : g_loop_even
      assign loop_bit = regen[SEGS-1];
   end else begin : g_loop_odd
      assign loop_bit = ~regen[SEGS-1];
   end

   assign stream_bit = loop_bit;

   for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      localparam int P = t * TAP_SPACING + TAP_PHASE;
      if (P < HALF_BITS) begin : g_on
         assign taps[t] = seg_q[P / SEG_LEN][P % SEG_LEN];
      end else begin : g_off
         assign taps[t] = 1'b0;
      end
   end

   AST_WR_ENTRY: assert property (@(posedge clk) disable iff (rst)
      shift && wr_en |=> seg_q[0][0] == $past(wr_bit)); // R3

   AST_LOOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
      shift && !wr_en |=> seg_q[0][0] == $past(stream_bit)); // R2

endmodule

// File: rtl/rsm_rotor.sv
module rsm_rotor #(
   parameter int N     = 2080,
   parameter int POS_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift,
   output logic [POS_W-1:0] rot_q,
   output logic [POS_W-1:0] rot_nxt
);

   always_comb begin
      rot_nxt = rot_q;
      if (shift) begin
         rot_nxt = (rot_q == POS_W'(N - 1)) ? '0 : rot_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rot_q <= '0;
      end else begin
         rot_q <= rot_nxt;
      end
   end

   AST_ROT_RANGE: assert property (@(posedge clk) disable iff (rst)
      rot_q < POS_W'(N)); // R4

   AST_ROT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(rot_q)); // R4

   AST_ROT_WRAP: assert property (@(posedge clk) disable iff (rst)
      shift && rot_q == POS_W'(N - 1) |=> rot_q == '0); // R4

   AST_ROT_RESET: assert property (@(posedge clk)
      $past(rst) |-> rot_q == '0); // R10

endmodule

// File: rtl/rsm_reader.sv
module rsm_reader
   import rsm_pkg::*;
#(
   parameter int N           = 2080,
   parameter int SEG_LEN     = 65,
   parameter int TAP_SPACING = 130,
   parameter int TAP_PHASE   = 129,
   parameter int NTAPS       = 16,
   parameter int POS_W       = 12,
   parameter int SLOT_W      = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift,
   input  logic              rd_req,
   input  logic              req_half,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic [POS_W-1:0]  rot_nxt,
   input  logic [NTAPS-1:0]  taps_even,
   input  logic [NTAPS-1:0]  taps_odd,
   output logic              rd_valid,
   output logic              rd_data
);

   localparam int   WAIT_W  = $clog2(TAP_SPACING);
   localparam int   TAP_W   = $clog2(NTAPS);
   localparam logic TAP_INV = crossing_parity(TAP_PHASE, SEG_LEN);

   logic              pending_q;
   half_e             half_q;
   logic [SLOT_W-1:0] slot_q;
   logic [WAIT_W-1:0] wait_q;
   logic [TAP_W-1:0]  tap_q;
   logic [WAIT_W:0]   shifts_q;

   logic              in_range;
   logic [WAIT_W-1:0] wait_d;
   logic [TAP_W-1:0]  tap_d;
   logic              tap_bit;

   assign in_range = {1'b0, req_slot} < (SLOT_W + 1)'(N);

   // Position of the requested slot after this edge, then distance to the next tap
   always_comb begin
      int pos;
      int phase;
      int tapn;
      pos = int'(rot_nxt) + N - 1 - int'(req_slot);
      if (pos >= N) begin
         pos = pos - N;
      end
      if (pos < 0) begin
         pos = 0;
      end
      phase = pos % TAP_SPACING;
      tapn  = pos / TAP_SPACING;
      if (phase <= TAP_PHASE) begin
         wait_d = WAIT_W'(TAP_PHASE - phase);
         tap_d  = TAP_W'(tapn);
      end else begin
         wait_d = WAIT_W'(TAP_PHASE + TAP_SPACING - phase);
         tap_d  = (tapn + 1 >= NTAPS) ? '0 : TAP_W'(tapn + 1);
      end
   end

   assign tap_bit = (half_q == HALF_ODD) ? taps_odd[tap_q] : taps_even[tap_q];

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         rd_valid  <= 1'b0;
         shifts_q  <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (pending_q) begin
            if (wait_q == '0) begin
               pending_q <= 1'b0;
               rd_valid  <= 1'b1;
               rd_data   <= tap_bit ^ TAP_INV;
            end else if (shift) begin
               wait_q   <= wait_q - 1'b1;
               shifts_q <= shifts_q + 1'b1;
            end
         end else if (rd_req && in_range) begin
            pending_q <= 1'b1;
            half_q    <= half_e'(req_half);
            slot_q    <= req_slot;
            wait_q    <= wait_d;
            tap_q     <= tap_d;
            shifts_q  <= '0;
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid); // R8

   AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (rst)
      pending_q |-> shifts_q < (WAIT_W + 1)'(TAP_SPACING)); // R7

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
      pending_q && rd_req |=> slot_q == $past(slot_q)); // R9

   AST_OOR_DROP: assert property (@(posedge clk) disable iff (rst)
      !pending_q && rd_req && !in_range |=> !pending_q); // R1

   AST_RESET_CLEAR: assert property (@(posedge clk)
      $past(rst) |-> !rd_valid && !pending_q); // R10

endmodule

// File: rtl/recirc_shift_mem.sv
module recirc_shift_mem #(
   parameter int SEG_LEN   = 65,
   parameter int SEGS      = 32,
   parameter int TAP_SEGS  = 2,
   parameter int TAP_PHASE = 129,
   parameter int HALF_BITS = SEG_LEN * SEGS,
   parameter int ADDR_W    = $clog2(2 * HALF_BITS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_data,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        ser_out,
   output logic              rd_valid,
   output logic              rd_data
);

   localparam int TAP_SPACING = SEG_LEN * TAP_SEGS;
   localparam int NTAPS       = SEGS / TAP_SEGS;
   localparam int POS_W       = $clog2(HALF_BITS);
   localparam int SLOT_W      = ADDR_W - 1;

   if (SEG_LEN < 2) begin : g_bad_seg
      $error("segment length must be at least 2");
   end
   if (TAP_SEGS < 1 || (SEGS % TAP_SEGS) != 0) begin : g_bad_tap
      $error("tap spacing must divide the half evenly");
   end
   if (NTAPS < 2) begin : g_bad_ntaps
      $error("at least two taps per half are required");
   end
   if (TAP_PHASE < 0 || TAP_PHASE >= TAP_SPACING) begin : g_bad_phase
      $error("tap phase must lie within one tap spacing");
   end
   if (HALF_BITS != SEG_LEN * SEGS) begin : g_bad_half
      $error("half size must equal segment length times segment count");
   end
   if (SLOT_W < POS_W) begin : g_bad_addr
      $error("address too narrow for the half size");
   end

   logic             shift_g;
   logic [POS_W-1:0] rot_q;
   logic [POS_W-1:0] rot_nxt;
   logic [NTAPS-1:0] taps [2];

   assign shift_g = shift_en & ~rst;

   rsm_rotor #(.N(HALF_BITS), .POS_W(POS_W)) u_rotor (
      .clk     (clk),
      .rst     (rst),
      .shift   (shift_g),
      .rot_q   (rot_q),
      .rot_nxt (rot_nxt)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      rsm_half #(
         .SEG_LEN     (SEG_LEN),
         .SEGS        (SEGS),
         .TAP_SPACING (TAP_SPACING),
         .TAP_PHASE   (TAP_PHASE),
         .NTAPS       (NTAPS)
      ) u_half (
         .clk        (clk),
         .rst        (rst),
         .shift      (shift_g),
         .wr_en      (wr_en),
         .wr_bit     (wr_data[h]),
         .stream_bit (ser_out[h]),
         .taps       (taps[h])
      );
   end

   rsm_reader #(
      .N           (HALF_BITS),
      .SEG_LEN     (SEG_LEN),
      .TAP_SPACING (TAP_SPACING),
      .TAP_PHASE   (TAP_PHASE),
      .NTAPS       (NTAPS),
      .POS_W       (POS_W),
      .SLOT_W      (SLOT_W)
   ) u_reader (
      .clk       (clk),
      .rst       (rst),
      .shift     (shift_g),
      .rd_req    (rd_req),
      .req_half  (rd_addr[0]),
      .req_slot  (rd_addr[ADDR_W-1:1]),
      .rot_nxt   (rot_nxt),
      .taps_even (taps[0]),
      .taps_odd  (taps[1]),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(ser_out)); // R4

endmodule

// File: tb/tb_recirc_shift_mem.sv
`timescale 1ns/1ps
module tb_recirc_shift_mem;

   localparam int N  = 2080;
   localparam int SP = 130;
   localparam int PH = 129;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        shift_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_data = 2'b00;
   logic        rd_req = 1'b0;
   logic [12:0] rd_addr = '0;
   logic [1:0]  ser_out;
   logic        rd_valid;
   logic        rd_data;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  rot_m    = 0;
   bit  done     = 0;
   bit  mem [2][N];

   always #4 clk = ~clk;

   recirc_shift_mem dut (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .ser_out  (ser_out),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // Called at a negedge; drives one edge, updates the model, returns at the next negedge
   task automatic step(input bit sh, input bit we, input bit [1:0] wd, input bit rq, input int ad);
      shift_en = sh;
      wr_en    = we;
      wr_data  = wd;
      rd_req   = rq;
      rd_addr  = 13'(ad);
      @(posedge clk);
      if (rst) begin
         rot_m = 0;
      end else if (sh) begin
         if (we) begin
            mem[0][rot_m] = wd[0];
            mem[1][rot_m] = wd[1];
         end
         rot_m = (rot_m + 1) % N;
      end
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   function automatic int pos_of(input int s);
      return (rot_m + N - 1 - s) % N;
   endfunction

   task automatic fill_all();
      for (int i = 0; i < N; i++) begin
         step(1, 1, 2'($urandom), 0, 0);
      end
   endtask

   task automatic verify_loop(input string tag);
      int bad = 0;
      for (int i = 0; i < N; i++) begin
         if (ser_out[0] != mem[0][rot_m] || ser_out[1] != mem[1][rot_m]) begin
            bad++;
         end
         step(1, 0, 2'b00, 0, 0);
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic do_read(input int addr, input int shprob, input bit dup, input int dup_addr,
                          input bit bound, input string tag);
      int  h = addr & 1;
      int  s = addr >> 1;
      bit  got = 0;
      bit  early = 0;
      int  lat = 0;
      bit  match;
      step(($urandom % 100) < shprob, 0, 2'b00, 1, addr);
      for (int c = 0; c < 400 && !got; c++) begin
         match = (pos_of(s) % SP) == PH;
         step(($urandom % 100) < shprob, 0, 2'b00, dup && c == 0, dup_addr);
         if (match) begin
            got = 1;
            lat = c + 1;
            chk(rd_valid == 1'b1, {"R7 valid after tap ", tag}, rd_valid, 1);
            chk(rd_data == mem[h][s], {"R6 read data ", tag}, rd_data, mem[h][s]);
         end else if (rd_valid) begin
            early = 1;
         end
      end
      chk(!early, {"R8 no stray strobe ", tag}, early, 0);
      if (bound) begin
         chk(lat >= 1 && lat <= SP, {"R7 latency bound ", tag}, lat, SP);
      end
      step(1, 0, 2'b00, 0, 0);
      chk(rd_valid == 1'b0, {"R8 single cycle ", tag}, rd_valid, 0);
      if (dup) begin
         int extra = 0;
         for (int c = 0; c < SP + 10; c++) begin
            step(1, 0, 2'b00, 0, 0);
            if (rd_valid) extra++;
         end
         chk(extra == 0, {"R9 busy request ignored ", tag}, extra, 0);
      end
   endtask

   task automatic no_valid_run(input int cycles, input string tag);
      int seen = 0;
      for (int c = 0; c < cycles; c++) begin
         step(1, 0, 2'b00, 0, 0);
         if (rd_valid) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 190000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int  s;
      void'($urandom(32'd4711));
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 3; i++) step(1, 0, 2'b00, 0, 0);
      chk(rd_valid == 1'b0, "R10 rd_valid low in reset", rd_valid, 0);
      rst = 1'b0;

      // R3 fill every slot, R2 R4 R5 stream check over a full loop
      fill_all();
      verify_loop("R2 R4 R5 stream after fill");

      // R3 R4 write without shift has no effect, stream stable
      begin
         int bad = 0;
         bit [1:0] held = ser_out;
         for (int i = 0; i < 6; i++) begin
            step(0, 1, ~{mem[1][rot_m], mem[0][rot_m]}, 0, 0);
            if (ser_out != held || ser_out[0] != mem[0][rot_m] || ser_out[1] != mem[1][rot_m]) bad++;
         end
         chk(bad == 0, "R3 R4 write without shift ignored", bad, 0);
      end

      // R3 random sparse writes, then a full loop of retention
      for (int i = 0; i < N; i++) begin
         step(1, ($urandom % 4) == 0, 2'($urandom), 0, 0);
      end
      verify_loop("R3 sparse writes visible");
      verify_loop("R2 retention second loop");

      // R1 half select: find a slot whose two halves differ
      s = 0;
      for (int i = 0; i < N; i++) begin
         if (mem[0][i] != mem[1][i]) begin
            s = i;
            break;
         end
      end
      do_read(2 * s, 100, 0, 0, 1, "R1 even half");
      do_read(2 * s + 1, 100, 0, 0, 1, "R1 odd half");

      // R7 directed phases: on tap at capture, one before, just past
      s = (rot_m + 1 - 1 - PH + N) % N;
      do_read(2 * s, 100, 0, 0, 1, "R7 on tap");
      s = (rot_m - 128 + N) % N;
      do_read(2 * s + 1, 100, 0, 0, 1, "R7 one before tap");
      s = (rot_m - 130 + N) % N;
      do_read(2 * s, 100, 0, 0, 1, "R7 worst case");
      s = N - 1;
      do_read(2 * s + 1, 100, 0, 0, 1, "R1 last slot");

      // R1 out of range slots dropped
      step(1, 0, 2'b00, 1, 2 * N);
      no_valid_run(SP + 10, "R1 slot 2080 dropped");
      step(1, 0, 2'b00, 1, 13'h1fff);
      no_valid_run(SP + 10, "R1 slot 4095 dropped");

      // R9 second request while pending
      s = (rot_m + 5) % N;
      do_read(2 * s, 100, 1, 2 * ((s + 700) % N) + 1, 1, "R9 duplicate");

      // R6 random reads, continuous shifting
      for (int i = 0; i < 30; i++) begin
         do_read(int'($urandom % (2 * N)), 100, 0, 0, 1, "R6 random");
      end
      // R7 random reads with shift gaps
      for (int i = 0; i < 10; i++) begin
         do_read(int'($urandom % (2 * N)), 70, 0, 0, 0, "R7 gapped");
      end

      // R10 reset drops a pending read
      s = (rot_m - 130 + N) % N;
      step(1, 0, 2'b00, 1, 2 * s);
      for (int i = 0; i < 10; i++) step(1, 0, 2'b00, 0, 0);
      rst = 1'b1;
      step(1, 0, 2'b00, 0, 0);
      rst = 1'b0;
      chk(rd_valid == 1'b0, "R10 rd_valid low after reset", rd_valid, 0);
      no_valid_run(SP + 10, "R10 pending read dropped");

      // after reset the contents are undefined: refill and read again
      fill_all();
      verify_loop("R4 R5 stream after reset refill");
      do_read(int'($urandom % (2 * N)), 100, 0, 0, 1, "R6 after reset");

      finish_run();
   end

endmodule